// File: doc/BRIEF.md
# XY Wormhole Mesh Router Node

This block is one node of a two-dimensional mesh network-on-chip that moves messages between processor cores and memory cores. It has four neighbour links (north, east, south, west) and one local link to the attached core. Messages travel as packets of flits: a packet opens with a head flit naming the destination node, may carry body flits, and closes with a tail flit. A packet of one flit uses the single type. Every link uses valid/ready flow control. The node sits at fixed coordinates (`MY_X`, `MY_Y`). East is X+1 and north is Y+1. The default node is an interior position of a 3 by 6 mesh.

Each arriving packet is steered by dimension order. The X difference is removed completely before any Y step is taken. An output is held by one input from the head flit to the tail flit (wormhole switching). When several inputs want a free output, a round-robin arbiter chooses between them. A packet that has reached its destination is handed to the local core through one of two receive queues. One queue holds traffic sent by processor cores and the other holds traffic sent by memory cores, chosen by a sender-kind bit in the head flit. A full receive queue holds back only packets that are bound for that queue.

Flit layout (`DW+2` bits): bits [DW+1:DW] carry the type and bits [DW-1:0] carry the payload. In a head flit, payload bits [XW-1:0] are the destination X, bits [XW+YW-1:XW] are the destination Y, and bit [XW+YW] is the sender kind (0 = processor core, 1 = memory core).

Top module: `xy_mesh_router`

## Requirements
- R1: After reset all four mesh outputs and both receive queues show valid low, and all five inputs show ready high.
- R2: An opening flit (head 2'b01 or single 2'b11) whose destination X is greater than `MY_X` leaves east (index 1), and one with a smaller X leaves west (index 3), whatever its Y. Only when X matches does it go north (index 0) for a greater Y or south (index 2) for a smaller Y.
- R3: A packet whose destination equals (`MY_X`, `MY_Y`) is delivered to the processor receive queue when the sender-kind bit (payload bit XW+YW) is 0, and to the memory receive queue when it is 1.
- R4: Once a head flit (2'b01) takes an output, that output carries only body (2'b00) and tail (2'b10) flits of the same packet, in order, until the tail passes. Flits of other packets for that output wait.
- R5: Inputs that compete for a free output are served round-robin. With two inputs that both have packets waiting, the grants alternate between them.
- R6: Each input buffers `IN_DEPTH` flits and drops its ready when that buffer is full.
- R7: A mesh output whose ready is low keeps valid high and its flit unchanged until the flit is taken, and no flit is lost or repeated.
- R8: A full receive queue stalls only packets bound for it. Packets for the other receive queue and for mesh outputs keep moving. The stalled packets are delivered in order once the queue drains.
- R9: A single flit (2'b11) does not hold its output, so the next packet can use that output at once.
- R10: A flit taken at an input on one clock edge, with its path idle, appears valid at its mesh output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit valid per input (0 N, 1 E, 2 S, 3 W, 4 local) |
| in_ready | output | 5 | Input can take a flit |
| in_flit | input | 5*(DW+2) | Input flits, input i at bits [i*(DW+2) +: DW+2] |
| out_valid | output | 4 | Flit valid per mesh output (0 N, 1 E, 2 S, 3 W) |
| out_ready | input | 4 | Neighbour takes the flit |
| out_flit | output | 4*(DW+2) | Mesh output flits, same slicing as in_flit |
| rxp_valid | output | 1 | Processor receive queue not empty |
| rxp_ready | input | 1 | Core pops the processor receive queue |
| rxp_flit | output | DW+2 | Oldest flit of the processor receive queue |
| rxm_valid | output | 1 | Memory receive queue not empty |
| rxm_ready | input | 1 | Core pops the memory receive queue |
| rxm_flit | output | DW+2 | Oldest flit of the memory receive queue |

## Verification
The assertions assume well-formed packets. Every input stream is a sequence of single flits or of one head, any number of bodies and one tail. A head never names a direction it arrived from in a way that loops, and an input holds a flit steady while its valid is high and ready is low. The stimulus builds packets only through helper functions that produce those shapes. It sends destinations that are legal mesh coordinates, and it raises valid only with a stable flit that it keeps until the ready sampled before the edge is high.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flit_type_e;

  localparam int NIN   = 5;
  localparam int NMESH = 4;
  localparam int NOUT  = 6;
  localparam int P_N   = 0;
  localparam int P_E   = 1;
  localparam int P_S   = 2;
  localparam int P_W   = 3;
  localparam int O_RXP = 4;
  localparam int O_RXM = 5;

  function automatic logic opens_pkt(input logic [1:0] t);
    return (t == FT_HEAD) || (t == FT_SINGLE);
  endfunction
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end

  // R5
  grant_in_req_chk: assert property (@(posedge clk) disable iff (rst) gnt_any |-> req[gnt_idx]);
  // R5
  grant_live_chk: assert property (@(posedge clk) disable iff (rst) (|req) |-> gnt_any);
endmodule

// File: rtl/router_out_stage.sv
module router_out_stage #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         space
);
  assign space = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (space) valid <= load;
  end

  always_ff @(posedge clk) begin
    if (load && space) dout <= din;
  end

  // R7
  hold_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));
  // R7
  load_has_room_chk: assert property (@(posedge clk) disable iff (rst) load |-> space);
endmodule

// File: rtl/xy_mesh_router.sv
module xy_mesh_router
  import mesh_router_pkg::*;
#(
  parameter int XW         = 3,
  parameter int YW         = 3,
  parameter int DW         = 32,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 2,
  parameter int IN_DEPTH   = 2,
  parameter int RX_DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NIN-1:0]           in_valid,
  output logic [NIN-1:0]           in_ready,
  input  logic [NIN*(DW+2)-1:0]    in_flit,
  output logic [NMESH-1:0]         out_valid,
  input  logic [NMESH-1:0]         out_ready,
  output logic [NMESH*(DW+2)-1:0]  out_flit,
  output logic                     rxp_valid,
  input  logic                     rxp_ready,
  output logic [DW+1:0]            rxp_flit,
  output logic                     rxm_valid,
  input  logic                     rxm_ready,
  output logic [DW+1:0]            rxm_flit
);
  localparam int FW  = DW + 2;
  localparam int OW  = $clog2(NOUT);
  localparam int IIW = $clog2(NIN);
  localparam int KB  = XW + YW;
  localparam logic [XW-1:0] HX = XW'(MY_X);
  localparam logic [YW-1:0] HY = YW'(MY_Y);

  function automatic logic [OW-1:0] xy_route(input logic [KB:0] h);
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    dx = h[XW-1:0];
    dy = h[KB-1:XW];
    if (dx > HX)      return OW'(P_E);
    else if (dx < HX) return OW'(P_W);
    else if (dy > HY) return OW'(P_N);
    else if (dy < HY) return OW'(P_S);
    else if (h[KB])   return OW'(O_RXM);
    else              return OW'(O_RXP);
  endfunction

  // input side
  logic [FW-1:0]  hd     [NIN];
  logic [OW-1:0]  rt_new [NIN];
  logic [OW-1:0]  rt_q   [NIN];
  logic [OW-1:0]  want   [NIN];
  logic [NIN-1:0] ib_full, ib_empty, hd_ok, pop;

  // output side
  logic [NOUT-1:0] locked, fire, space, gany;
  logic [IIW-1:0]  owner [NOUT];
  logic [IIW-1:0]  gidx  [NOUT];
  logic [IIW-1:0]  sel   [NOUT];
  logic [FW-1:0]   odata [NOUT];

  assign hd_ok = ~ib_empty;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    router_fifo #(.W(FW), .DEPTH(IN_DEPTH)) u_buf (
      .clk(clk), .rst(rst),
      .push(in_valid[i] && in_ready[i]), .wdata(in_flit[i*FW +: FW]),
      .pop(pop[i]), .rdata(hd[i]), .full(ib_full[i]), .empty(ib_empty[i])
    );
    assign in_ready[i] = !ib_full[i];
    assign rt_new[i]   = xy_route(hd[i][KB:0]);
    assign want[i]     = opens_pkt(hd[i][FW-1 -: 2]) ? rt_new[i] : rt_q[i];

    always_ff @(posedge clk) begin
      if (rst) rt_q[i] <= '0;
      else if (pop[i] && opens_pkt(hd[i][FW-1 -: 2])) rt_q[i] <= rt_new[i];
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [NIN-1:0] arb_req;

    always_comb begin
      for (int i = 0; i < NIN; i++)
        arb_req[i] = hd_ok[i] && (want[i] == OW'(o)) && opens_pkt(hd[i][FW-1 -: 2]);
    end

    router_rr_arb #(.N(NIN)) u_arb (
      .clk(clk), .rst(rst), .req(arb_req), .adv(fire[o] && !locked[o]),
      .gnt_idx(gidx[o]), .gnt_any(gany[o])
    );

    assign sel[o]   = locked[o] ? owner[o] : gidx[o];
    assign fire[o]  = space[o] && (locked[o] ? (hd_ok[owner[o]] && (want[owner[o]] == OW'(o)))
                                             : gany[o]);
    assign odata[o] = hd[sel[o]];

    always_ff @(posedge clk) begin
      if (rst) begin
        locked[o] <= 1'b0;
        owner[o]  <= '0;
      end else if (fire[o]) begin
        if (odata[o][FW-1 -: 2] == FT_HEAD) begin
          locked[o] <= 1'b1;
          owner[o]  <= sel[o];
        end else if (odata[o][FW-1 -: 2] == FT_TAIL) begin
          locked[o] <= 1'b0;
        end
      end
    end

    // R4
    locked_no_open_chk: assert property (@(posedge clk) disable iff (rst)
      (locked[o] && fire[o]) |-> !opens_pkt(odata[o][FW-1 -: 2]));
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NOUT; o++)
      if (fire[o]) pop[sel[o]] = 1'b1;
  end

  for (genvar o = 0; o < NMESH; o++) begin : g_mesh
    router_out_stage #(.W(FW)) u_stage (
      .clk(clk), .rst(rst), .load(fire[o]), .din(odata[o]), .ready(out_ready[o]),
      .valid(out_valid[o]), .dout(out_flit[o*FW +: FW]), .space(space[o])
    );
  end

  logic rxp_full, rxp_empty, rxm_full, rxm_empty;

  router_fifo #(.W(FW), .DEPTH(RX_DEPTH)) u_rxp (
    .clk(clk), .rst(rst), .push(fire[O_RXP]), .wdata(odata[O_RXP]),
    .pop(rxp_valid && rxp_ready), .rdata(rxp_flit), .full(rxp_full), .empty(rxp_empty)
  );
  router_fifo #(.W(FW), .DEPTH(RX_DEPTH)) u_rxm (
    .clk(clk), .rst(rst), .push(fire[O_RXM]), .wdata(odata[O_RXM]),
    .pop(rxm_valid && rxm_ready), .rdata(rxm_flit), .full(rxm_full), .empty(rxm_empty)
  );

  assign space[O_RXP] = !rxp_full;
  assign space[O_RXM] = !rxm_full;
  assign rxp_valid    = !rxp_empty;
  assign rxm_valid    = !rxm_empty;

  // R2
  x_before_y_chk: assert property (@(posedge clk) disable iff (rst)
    (fire[P_E] && opens_pkt(odata[P_E][FW-1 -: 2]) |-> odata[P_E][XW-1:0] > HX) and
    (fire[P_W] && opens_pkt(odata[P_W][FW-1 -: 2]) |-> odata[P_W][XW-1:0] < HX));
  // R2
  y_after_x_chk: assert property (@(posedge clk) disable iff (rst)
    (fire[P_N] && opens_pkt(odata[P_N][FW-1 -: 2]) |->
      (odata[P_N][XW-1:0] == HX) && (odata[P_N][KB-1:XW] > HY)) and
    (fire[P_S] && opens_pkt(odata[P_S][FW-1 -: 2]) |->
      (odata[P_S][XW-1:0] == HX) && (odata[P_S][KB-1:XW] < HY)));
  // R3
  eject_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (fire[O_RXM] && opens_pkt(odata[O_RXM][FW-1 -: 2]) |-> odata[O_RXM][KB:0] == {1'b1, HY, HX}) and
    (fire[O_RXP] && opens_pkt(odata[O_RXP][FW-1 -: 2]) |-> odata[O_RXP][KB:0] == {1'b0, HY, HX}));
endmodule

// File: tb/tb_xy_mesh_router.sv
module tb_xy_mesh_router;
  localparam int FW = 34;

  logic            clk = 1'b0;
  logic            rst;
  logic [4:0]      in_valid;
  logic [4:0]      in_ready;
  logic [5*FW-1:0] in_flit;
  logic [3:0]      out_valid;
  logic [3:0]      out_ready;
  logic [4*FW-1:0] out_flit;
  logic            rxp_valid, rxp_ready, rxm_valid, rxm_ready;
  logic [FW-1:0]   rxp_flit, rxm_flit;

  xy_mesh_router dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .rxp_valid(rxp_valid), .rxp_ready(rxp_ready), .rxp_flit(rxp_flit),
    .rxm_valid(rxm_valid), .rxm_ready(rxm_ready), .rxm_flit(rxm_flit)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [FW-1:0] lg [6][64];
  int            lc [6];

  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < 4; o++)
        if (out_valid[o] && out_ready[o] && lc[o] < 64) begin
          lg[o][lc[o]] = out_flit[o*FW +: FW];
          lc[o]++;
        end
      if (rxp_valid && rxp_ready && lc[4] < 64) begin lg[4][lc[4]] = rxp_flit; lc[4]++; end
      if (rxm_valid && rxm_ready && lc[5] < 64) begin lg[5][lc[5]] = rxm_flit; lc[5]++; end
    end
  end

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input int dx, input int dy,
                                       input bit kind, input logic [15:0] tag);
    return {t, tag, 9'b0, kind, dy[2:0], dx[2:0]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int o = 0; o < 6; o++) lc[o] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int p, input logic [FW-1:0] f);
    @(posedge clk); #1;
    in_valid[p] = 1'b1;
    in_flit[p*FW +: FW] = f;
    forever begin
      @(negedge clk);
      if (in_ready[p]) break;
    end
    @(posedge clk); #1;
    in_valid[p] = 1'b0;
  endtask

  task automatic send_pkt3(input int p, input int dx, input int dy, input logic [15:0] tag);
    send(p, mk(2'b01, dx, dy, 1'b0, tag));
    send(p, mk(2'b00, 0, 0, 1'b0, tag));
    send(p, mk(2'b10, 0, 0, 1'b0, tag));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 4'b0, "R1 mesh valid after reset", 64'(out_valid), 0);
    chk(!rxp_valid && !rxm_valid, "R1 rx valid after reset", {rxp_valid, rxm_valid}, 0);
    chk(in_ready == 5'h1f, "R1 in_ready after reset", 64'(in_ready), 64'h1f);
  endtask

  task automatic route_case(input int p, input int dx, input int dy, input bit kind,
                            input int exp, input string req);
    logic [FW-1:0] f;
    int total;
    f = mk(2'b11, dx, dy, kind, 16'(100 + dx * 10 + dy));
    clear_logs();
    send(p, f);
    idle(5);
    total = lc[0] + lc[1] + lc[2] + lc[3] + lc[4] + lc[5];
    chk(lc[exp] == 1 && total == 1, {req, " sink count"}, 64'(lc[exp] * 100 + total), 64'(101));
    chk(lg[exp][0] == f, {req, " sink flit"}, 64'(lg[exp][0]), 64'(f));
  endtask

  task automatic t_route();
    route_case(4, 2, 0, 1'b0, 1, "R2 X+ goes east before Y");
    route_case(4, 0, 5, 1'b0, 3, "R2 X- goes west before Y");
    route_case(4, 1, 4, 1'b0, 0, "R2 Y+ goes north");
    route_case(4, 1, 0, 1'b0, 2, "R2 Y- goes south");
    route_case(3, 1, 2, 1'b0, 4, "R3 local proc kind");
    route_case(0, 1, 2, 1'b1, 5, "R3 local mem kind");
  endtask

  task automatic t_latency();
    clear_logs();
    @(posedge clk); #1;
    in_valid[4] = 1'b1;
    in_flit[4*FW +: FW] = mk(2'b11, 2, 2, 1'b0, 16'h0aa);
    @(negedge clk);
    chk(in_ready[4], "R10 input ready", 64'(in_ready[4]), 1);
    @(posedge clk); #1;
    in_valid[4] = 1'b0;
    @(negedge clk);
    chk(!out_valid[1], "R10 not yet at output", 64'(out_valid[1]), 0);
    @(negedge clk);
    chk(out_valid[1], "R10 at output one edge later", 64'(out_valid[1]), 1);
    idle(3);
  endtask

  task automatic t_wormhole();
    logic [FW-1:0] held;
    bit ok;
    clear_logs();
    out_ready[1] = 1'b0;
    fork
      send_pkt3(3, 2, 1, 16'h0a1);
      send_pkt3(2, 2, 4, 16'h0b2);
    join_none
    idle(8);
    @(negedge clk);
    held = out_flit[1*FW +: FW];
    chk(out_valid[1], "R7 valid held while stalled", 64'(out_valid[1]), 1);
    idle(3);
    @(negedge clk);
    chk(out_valid[1] && out_flit[1*FW +: FW] == held, "R7 flit stable while stalled",
        64'(out_flit[1*FW +: FW]), 64'(held));
    @(posedge clk); #1;
    out_ready[1] = 1'b1;
    wait fork;
    idle(10);
    chk(lc[1] == 6, "R4 all flits of both packets out", 64'(lc[1]), 6);
    ok = 1;
    for (int k = 0; k < 6; k++) begin
      logic [1:0] et;
      et = (k % 3 == 0) ? 2'b01 : ((k % 3 == 1) ? 2'b00 : 2'b10);
      if (lg[1][k][33:32] != et) ok = 0;
    end
    chk(ok, "R4 type order head body tail twice", 64'(lg[1][1][33:32]), 0);
    chk(lg[1][0][31:16] == lg[1][1][31:16] && lg[1][1][31:16] == lg[1][2][31:16] &&
        lg[1][3][31:16] == lg[1][4][31:16] && lg[1][4][31:16] == lg[1][5][31:16] &&
        lg[1][0][31:16] != lg[1][3][31:16], "R4 packets not interleaved",
        {lg[1][0][31:16], lg[1][1][31:16], lg[1][3][31:16], lg[1][4][31:16]}, 0);
  endtask

  task automatic t_rr();
    bit ok;
    clear_logs();
    out_ready[1] = 1'b0;
    fork
      begin send(3, mk(2'b11, 2, 0, 1'b0, 16'd1)); send(3, mk(2'b11, 2, 0, 1'b0, 16'd2)); end
      begin send(2, mk(2'b11, 2, 5, 1'b0, 16'd3)); send(2, mk(2'b11, 2, 5, 1'b0, 16'd4)); end
    join_none
    idle(8);
    out_ready[1] = 1'b1;
    wait fork;
    idle(8);
    chk(lc[1] == 4, "R9 singles leave output free", 64'(lc[1]), 4);
    ok = 1;
    for (int k = 0; k < 3; k++)
      if ((lg[1][k][31:16] <= 2) == (lg[1][k+1][31:16] <= 2)) ok = 0;
    chk(ok, "R5 grants alternate between inputs",
        {lg[1][0][31:16], lg[1][1][31:16], lg[1][2][31:16], lg[1][3][31:16]}, 0);
    ok = 1;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (lg[1][a][31:16] == 2 && lg[1][b][31:16] == 1) ok = 0;
        else if (lg[1][a][31:16] == 4 && lg[1][b][31:16] == 3) ok = 0;
    chk(ok, "R5 per-input order kept", {lg[1][0][31:16], lg[1][1][31:16]}, 0);
  endtask

  task automatic t_inbuf();
    clear_logs();
    out_ready[1] = 1'b0;
    send(3, mk(2'b11, 2, 2, 1'b0, 16'd31));
    send(3, mk(2'b11, 2, 2, 1'b0, 16'd32));
    send(3, mk(2'b11, 2, 2, 1'b0, 16'd33));
    @(negedge clk);
    chk(!in_ready[3], "R6 ready low with buffer full", 64'(in_ready[3]), 0);
    idle(3);
    @(negedge clk);
    chk(!in_ready[3], "R6 ready stays low while stalled", 64'(in_ready[3]), 0);
    @(posedge clk); #1;
    out_ready[1] = 1'b1;
    idle(8);
    chk(lc[1] == 3 && lg[1][0][31:16] == 31 && lg[1][1][31:16] == 32 && lg[1][2][31:16] == 33,
        "R6 buffered flits delivered in order", 64'(lc[1]), 3);
    chk(in_ready[3], "R6 ready back after drain", 64'(in_ready[3]), 1);
  endtask

  task automatic t_rxfull();
    bit ok;
    clear_logs();
    rxp_ready = 1'b0;
    for (int k = 0; k < 5; k++) send(0, mk(2'b11, 1, 2, 1'b0, 16'(10 + k)));
    idle(4);
    send(1, mk(2'b11, 1, 2, 1'b1, 16'd20));
    send(2, mk(2'b11, 0, 2, 1'b0, 16'd21));
    idle(6);
    chk(lc[5] == 1 && lg[5][0][31:16] == 20, "R8 mem queue flows while proc queue full",
        64'(lc[5]), 1);
    chk(lc[3] == 1 && lg[3][0][31:16] == 21, "R8 mesh output flows while proc queue full",
        64'(lc[3]), 1);
    chk(lc[4] == 0 && rxp_valid && rxp_flit[31:16] == 10, "R8 proc queue holds oldest",
        64'(rxp_flit[31:16]), 10);
    @(posedge clk); #1;
    rxp_ready = 1'b1;
    idle(14);
    ok = (lc[4] == 5);
    for (int k = 0; k < 5; k++) if (lg[4][k][31:16] != 16'(10 + k)) ok = 0;
    chk(ok, "R8 stalled packets delivered in order", 64'(lc[4]), 5);
  endtask

  initial begin
    rst = 1'b1;
    in_valid = '0;
    in_flit = '0;
    out_ready = 4'hf;
    rxp_ready = 1'b1;
    rxm_ready = 1'b1;
    clear_logs();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_route();
    t_latency();
    t_wormhole();
    t_rr();
    t_inbuf();
    t_rxfull();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule